// File: doc/BRIEF.md
# Peripheral Request Channel Router

This block sits between a large set of peripheral DMA request lines and a bank of DMA channel engines. Each request line owns a small map entry that names one target channel and carries a valid flag. A line whose entry is valid drives the request level of its target channel. A line whose entry is not valid is dropped. When several valid lines name the same channel, that channel sees the OR of their levels.

The block watches each channel's combined request level and emits a single-cycle event whenever the level changes. A rising level produces a request-after-stop event, and a falling level produces an end-of-receive event. The channel engines consume these events. Software reaches the map entries through a simple word-addressed register port. The port rejects any write that would route a valid line to a channel that does not exist, and it reports the rejection on an error output.

Top module: `dreq_router`

## Requirements
- R1: After reset every map entry reads 0x00, and all channel levels, all event outputs and the error output are low.
- R2: Entries 0 to 63 are written and read at word offsets 0x100 + 4·n. The read data is the 8-bit value last accepted. Bit 7 is the valid flag and bits 4:0 are the target channel.
- R3: Entries 64 to 74 are written and read at word offsets 0x1100 + 4·(n−64), and they route requests exactly like the low entries.
- R4: A request line whose entry is valid raises ch_req_o at its target channel on the clock edge after it is sampled high. The level drops on the edge after the line is sampled low.
- R5: A request line whose entry has bit 7 clear has no effect on any channel level or event.
- R6: When a channel's combined level goes from low to high, ch_ras_o for that channel is high for exactly one cycle, in the same cycle that ch_req_o first shows the new level.
- R7: When a channel's combined level goes from high to low, ch_eor_o for that channel is high for exactly one cycle, in the same cycle that ch_req_o first shows low.
- R8: With several valid lines mapped to one channel, the channel level is their OR. Lines that join or leave while another line stays high produce no event.
- R9: A write with bit 7 set and a channel number not below NUM_CH is rejected. The entry keeps its old value and reg_err_o is high in the following cycle. A write with bit 7 clear is accepted whatever its channel number.
- R10: Writes to any offset outside the two entry windows, or not word aligned, change no entry, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | NUM_REQ | Synchronous peripheral request levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| reg_err_o | output | 1 | Pulse: previous write was rejected |
| ch_req_o | output | NUM_CH | Registered combined request level per channel |
| ch_ras_o | output | NUM_CH | Pulse: channel level rose |
| ch_eor_o | output | NUM_CH | Pulse: channel level fell |

## Verification
The routing is first exercised with one isolated line in each address window. This shows that both windows decode to the right entries and that a rise and a fall each give exactly one event, one cycle late. Two lines sharing a channel are then raised and dropped in overlapping order, which separates a true OR with edge detection on the combined level from per-line edge detection. A line with an invalid entry and a line whose entry was never written are driven high to show they are dropped. Rejected, accepted-invalid and off-window writes are each followed by a read-back, so a corrupted entry would be seen.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int unsigned MAP_W   = 8;
  localparam int unsigned CHN_W   = 5;
  localparam int unsigned LO_BASE = 32'h100;
  localparam int unsigned LO_CNT  = 64;
  localparam int unsigned HI_BASE = 32'h1100;

  typedef struct packed {
    logic             vld;
    logic [1:0]       rsvd;
    logic [CHN_W-1:0] chn;
  } map_entry_t;
endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
  import dreq_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned ADDR_W  = 13
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [MAP_W-1:0]              wdata_i,
  output logic [MAP_W-1:0]              rdata_o,
  output logic                          err_o,
  output logic [NUM_REQ-1:0]            vld_o,
  output logic [NUM_REQ-1:0][CHN_W-1:0] chn_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REQ);
  localparam int unsigned HI_CNT = NUM_REQ - LO_CNT;
  localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] LO_E = ADDR_W'(LO_BASE + 4 * LO_CNT);
  localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] HI_E = ADDR_W'(HI_BASE + 4 * HI_CNT);
  localparam logic [CHN_W:0]    CH_LIM = (CHN_W+1)'(NUM_CH);

  map_entry_t [NUM_REQ-1:0] map_q;
  map_entry_t               wr_ent;
  logic                     hit, bad, err_q;
  logic [IDX_W-1:0]         idx;

  assign wr_ent = map_entry_t'(wdata_i);
  assign bad    = wr_ent.vld && ({1'b0, wr_ent.chn} >= CH_LIM);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i >= LO_B && addr_i < LO_E) begin
        hit = 1'b1;
        idx = IDX_W'((addr_i - LO_B) >> 2);
      end else if (addr_i >= HI_B && addr_i < HI_E) begin
        hit = 1'b1;
        idx = IDX_W'(LO_CNT) + IDX_W'((addr_i - HI_B) >> 2);
      end
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q[r] <= '0;
      else if (we_i && hit && !bad && idx == IDX_W'(r)) map_q[r] <= wr_ent;
    end
    assign vld_o[r] = map_q[r].vld;
    assign chn_o[r] = map_q[r].chn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= we_i && hit && bad;
  end

  assign err_o   = err_q;
  assign rdata_o = hit ? MAP_W'(map_q[idx]) : '0;

  // R9: a rejected write leaves every entry untouched
  a_r9_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> map_q == $past(map_q));
endmodule

// File: rtl/dreq_chan_mux.sv
module dreq_chan_mux
  import dreq_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REQ-1:0]            req_i,
  input  logic [NUM_REQ-1:0]            vld_i,
  input  logic [NUM_REQ-1:0][CHN_W-1:0] chn_i,
  output logic [NUM_CH-1:0]             lvl_o
);
  logic [NUM_CH-1:0][NUM_REQ-1:0] sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
      assign sel[c][r] = vld_i[r] && (chn_i[r] == CHN_W'(c));
    end
    assign lvl_o[c] = |(sel[c] & req_i);
  end

  // R5: no channel is driven unless a request line with a valid entry is high
  a_r5_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_o) |-> (|(req_i & vld_i)));
endmodule

// File: rtl/dreq_edge_track.sv
module dreq_edge_track #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] lvl_i,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] rise_o,
  output logic [NUM_CH-1:0] fall_o
);
  logic [NUM_CH-1:0] lvl_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      rise_q <= lvl_i & ~lvl_q;
      fall_q <= ~lvl_i & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R6: a rise event only where the level is now high and was low
  a_r6_rise_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_q) |-> ((rise_q & ~lvl_q) == '0) && ((rise_q & $past(lvl_q)) == '0));
  // R7: a fall event only where the level is now low and was high
  a_r7_fall_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_q) |-> ((fall_q & lvl_q) == '0) && ((fall_q & ~$past(lvl_q)) == '0));
  // R6, R7: the two events never coincide on a channel
  a_r7_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q & fall_q) == '0);
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned ADDR_W  = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] dreq_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               reg_err_o,
  output logic [NUM_CH-1:0]  ch_req_o,
  output logic [NUM_CH-1:0]  ch_ras_o,
  output logic [NUM_CH-1:0]  ch_eor_o
);
  logic [NUM_REQ-1:0]            vld;
  logic [NUM_REQ-1:0][CHN_W-1:0] chn;
  logic [NUM_CH-1:0]             lvl;

  dreq_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_map (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .err_o(reg_err_o),
    .vld_o(vld), .chn_o(chn)
  );

  dreq_chan_mux #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) i_mux (
    .clk_i, .rst_ni,
    .req_i(dreq_i), .vld_i(vld), .chn_i(chn), .lvl_o(lvl)
  );

  dreq_edge_track #(.NUM_CH(NUM_CH)) i_edge (
    .clk_i, .rst_ni,
    .lvl_i(lvl), .lvl_o(ch_req_o), .rise_o(ch_ras_o), .fall_o(ch_eor_o)
  );
endmodule

// File: tb/test_dreq_router.sv
`timescale 1ns/1ps
module test_dreq_router;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] dreq = '0;
  logic          we = 1'b0;
  logic [12:0]   addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          err;
  logic [NC-1:0] req, ras, eor;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dreq_router #(.NUM_REQ(NR), .NUM_CH(NC), .ADDR_W(13)) i_dreq_router (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_err_o(err),
    .ch_req_o(req), .ch_ras_o(ras), .ch_eor_o(eor)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] off_of(input int n);
    if (n < 64) return 13'(32'h100 + 4 * n);
    return 13'(32'h1100 + 4 * (n - 64));
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d, output logic e);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    e = err;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 req", 32'(req), 0);
    check("R1 ras", 32'(ras), 0);
    check("R1 eor", 32'(eor), 0);
    check("R1 err", 32'(err), 0);
    rd(off_of(5), d);  check("R1 entry5", 32'(d), 0);
    rd(off_of(70), d); check("R1 entry70", 32'(d), 0);
  endtask

  task automatic t_map_rw;
    logic [7:0] d;
    logic e;
    wr(off_of(5), 8'h83, e);  check("R2 err5", 32'(e), 0);
    wr(off_of(63), 8'h05, e); check("R2 err63", 32'(e), 0);
    wr(off_of(64), 8'h8A, e); check("R3 err64", 32'(e), 0);
    wr(off_of(74), 8'h8F, e); check("R3 err74", 32'(e), 0);
    rd(13'h114, d);  check("R2 entry5", 32'(d), 32'h83);
    rd(13'h1FC, d);  check("R2 entry63", 32'(d), 32'h05);
    rd(13'h1100, d); check("R3 entry64", 32'(d), 32'h8A);
    rd(13'h1128, d); check("R3 entry74", 32'(d), 32'h8F);
  endtask

  task automatic t_rise_fall;
    @(negedge clk) dreq[5] = 1'b1;
    step;
    check("R4 level up", 32'(req), 32'h8);
    check("R6 ras pulse", 32'(ras), 32'h8);
    check("R7 no eor on rise", 32'(eor), 0);
    step;
    check("R6 ras one cycle", 32'(ras), 0);
    check("R4 level held", 32'(req), 32'h8);
    @(negedge clk) dreq[5] = 1'b0;
    step;
    check("R4 level down", 32'(req), 0);
    check("R7 eor pulse", 32'(eor), 32'h8);
    check("R6 no ras on fall", 32'(ras), 0);
    step;
    check("R7 eor one cycle", 32'(eor), 0);
  endtask

  task automatic t_ignored;
    @(negedge clk) dreq[63] = 1'b1;
    step;
    check("R5 invalid req", 32'(req), 0);
    check("R5 invalid ras", 32'(ras), 0);
    step;
    check("R5 invalid req later", 32'(req), 0);
    @(negedge clk) dreq[63] = 1'b0;
    step;
    check("R5 invalid eor", 32'(eor), 0);
  endtask

  task automatic t_shared;
    logic e;
    wr(off_of(6), 8'h83, e);
    @(negedge clk) dreq[5] = 1'b1;
    step;
    check("R8 first line ras", 32'(ras), 32'h8);
    @(negedge clk) dreq[6] = 1'b1;
    step;
    check("R8 join no ras", 32'(ras), 0);
    check("R8 join level", 32'(req), 32'h8);
    @(negedge clk) dreq[5] = 1'b0;
    step;
    check("R8 leave no eor", 32'(eor), 0);
    check("R8 leave level", 32'(req), 32'h8);
    @(negedge clk) dreq[6] = 1'b0;
    step;
    check("R8 last leave eor", 32'(eor), 32'h8);
    check("R8 last leave level", 32'(req), 0);
  endtask

  task automatic t_high_bank;
    @(negedge clk) begin dreq[64] = 1'b1; dreq[74] = 1'b1; end
    step;
    check("R3 high level", 32'(req), 32'h8400);
    check("R6 high ras", 32'(ras), 32'h8400);
    @(negedge clk) dreq[64] = 1'b0;
    step;
    check("R7 high eor", 32'(eor), 32'h0400);
    check("R3 high level after", 32'(req), 32'h8000);
    @(negedge clk) dreq[74] = 1'b0;
    step;
    check("R7 high eor 74", 32'(eor), 32'h8000);
  endtask

  task automatic t_error;
    logic [7:0] d;
    logic e;
    wr(off_of(5), 8'h90, e); check("R9 err flagged", 32'(e), 1);
    rd(off_of(5), d);        check("R9 entry kept", 32'(d), 32'h83);
    step;
    check("R9 err one cycle", 32'(err), 0);
    wr(off_of(74), 8'h9F, e); check("R9 err high bank", 32'(e), 1);
    rd(off_of(74), d);        check("R9 entry74 kept", 32'(d), 32'h8F);
    wr(off_of(5), 8'h1F, e); check("R9 invalid accepted", 32'(e), 0);
    rd(off_of(5), d);        check("R9 invalid stored", 32'(d), 32'h1F);
    wr(off_of(5), 8'h8F, e); check("R9 max channel ok", 32'(e), 0);
    rd(off_of(5), d);        check("R9 max channel stored", 32'(d), 32'h8F);
  endtask

  task automatic t_outside;
    logic [7:0] d;
    logic e;
    wr(13'h200, 8'h81, e);  check("R10 off-window err", 32'(e), 0);
    wr(13'h0FC, 8'h81, e);
    wr(13'h102, 8'h81, e);
    wr(13'h112C, 8'h81, e);
    rd(13'h200, d);  check("R10 read off", 32'(d), 0);
    rd(13'h102, d);  check("R10 read misaligned", 32'(d), 0);
    rd(13'h100, d);  check("R10 entry0 clean", 32'(d), 0);
    rd(13'h104, d);  check("R10 entry1 clean", 32'(d), 0);
    @(negedge clk) begin dreq[0] = 1'b1; dreq[1] = 1'b1; end
    step;
    check("R10 no route", 32'(req), 0);
    @(negedge clk) begin dreq[0] = 1'b0; dreq[1] = 1'b0; end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
    t_reset();
    t_map_rw();
    t_rise_fall();
    t_ignored();
    t_shared();
    t_high_bank();
    t_error();
    t_outside();
    finished = 1'b1;
    finish_run();
  end
endmodule